// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings an external TFT panel controller from power-off to a state where it accepts pixel data, and takes it back down again. It drives a platform power-enable output and the panel's reset pin, and it sends opcode and parameter bytes to a 9-bit serial link serializer through a valid/ready request port. Each byte carries a data/command flag beside its eight data bits. Every delay between steps is counted in pulses of an external 1 ms tick.

The whole sequence sits in a small step table computed at elaboration. Each entry is one of: power on, power off, assert reset, release reset, wait N ms, send opcode, send parameter, or end. Power-up runs from the start of the table. Power-down runs from a second entry point. A control FSM walks the table one step at a time. It accepts single-cycle enable and disable requests and reports which of four states it is in. A request in the wrong direction is held until the sequence in progress has finished.

Top module: `panel_power_seq`

## Requirements
- R1: After reset the block is off. `state` reads 0, `pwr_en` is 0, `cmd_valid` is 0 and `panel_rst` is at its asserted level. In the off state `pwr_en` stays 0 and `panel_rst` stays asserted.
- R2: `state` encodes 0 = off, 1 = powering up, 2 = active, 3 = powering down. An `en_req` pulse while off moves `state` to 1 on the next clock edge. The only transitions are 0→1, 1→2, 2→3 and 3→0.
- R3: Power-up raises `pwr_en` first and waits 1 ms. It then releases reset for 4 ms, asserts it for 10 ms, and releases it again for 50 ms before the first byte. A wait of N ms ends only after N·DELAY_SCALE+1 tick pulses have been counted. Between the two bounding events, N·DELAY_SCALE+1 or N·DELAY_SCALE+2 pulses are seen.
- R4: Power-up sends, in order: opcode 0x01, a 20 ms wait, opcode 0x11 and an 80 ms wait. It then sends the settings 0x36 with parameter 0x08, 0x3A with 0x66 and 0xC5 with 0x04, followed by opcode 0x29. `cmd_dc` is 0 on opcodes and 1 on parameters.
- R5: Power-up ends with opcode 0x2A and four parameter bytes holding WIDTH-1 as a 32-bit value, most significant byte first. Opcode 0x2B follows with HEIGHT-1 in the same form, and then opcode 0x2C.
- R6: Power-down sends opcode 0x28, then 0x10, then waits 2·FRAME_MS ms. It then drops `pwr_en`, asserts reset in the same cycle and returns to `state` 0.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_byte` and `cmd_dc` hold. A byte counts as sent on a clock edge where both are high. Stalls change only the timing, never the byte stream.
- R8: `rst_pol_high` = 1 makes the reset pin active-high, and 0 makes it active-low. The pin follows this input at once.
- R9: A `dis_req` that arrives while powering up is held. Power-down starts once the active state is reached. An `en_req` that arrives while powering down is held. Power-up starts again once the off state is reached.
- R10: `en_req` while active and `dis_req` while off have no effect. The state does not change and no byte is sent.
- R11: In the active state `pwr_en` is 1, reset is released and `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| rst_pol_high | input | 1 | 1: reset pin active-high, 0: active-low |
| en_req | input | 1 | Power-up request pulse |
| dis_req | input | 1 | Power-down request pulse |
| cmd_ready | input | 1 | Serializer accepts the offered byte |
| pwr_en | output | 1 | Platform power enable |
| panel_rst | output | 1 | Panel reset pin |
| cmd_valid | output | 1 | A byte is offered to the serializer |
| cmd_dc | output | 1 | 1 = parameter byte, 0 = opcode |
| cmd_byte | output | 8 | Byte offered to the serializer |
| state | output | 2 | 0 off, 1 powering up, 2 active, 3 powering down |

## Verification
Full power-up and power-down runs are made with the serializer always ready. This pins down the exact byte stream and the tick count between each pair of reset, power and byte events, so a shortened or misplaced wait shows up. The same sequences are repeated with a pseudo-random ready pattern and an active-low reset pin. This separates a byte stream that depends on the handshake from one that does not, and a pin that follows the polarity input from one that does not. Requests made in the opposite direction, part-way through each sequence, tell a held request apart from one that is dropped or acted on early. Requests made in a state where they mean nothing show that they are ignored.

// File: rtl/pps_pkg.sv
package pps_pkg;

   localparam int BYTE_W      = 8;
   localparam int STEP_COUNT  = 36;
   localparam int UP_ENTRY    = 0;
   localparam int DOWN_ENTRY  = 31;
   localparam int IDX_W       = $clog2(STEP_COUNT);

   typedef enum logic [1:0] {
      PH_OFF    = 2'd0,
      PH_UP     = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_DOWN   = 2'd3
   } phase_e;

   typedef enum logic [2:0] {
      OP_PWR_ON,
      OP_PWR_OFF,
      OP_RST_ASSERT,
      OP_RST_RELEASE,
      OP_WAIT,
      OP_CMD,
      OP_DATA,
      OP_END
   } op_e;

   typedef struct packed {
      op_e               op;
      logic [BYTE_W-1:0] arg;
   } step_t;

   function automatic step_t mk_step(op_e o, logic [BYTE_W-1:0] a);
      step_t s;
      s.op  = o;
      s.arg = a;
      return s;
   endfunction

   // Step table: power-up from UP_ENTRY, power-down from DOWN_ENTRY.
   function automatic step_t step_at(int idx, int width, int height, int frame_ms);
      logic [31:0] wl;
      logic [31:0] hl;
      step_t       s;
      wl = 32'(width - 1);
      hl = 32'(height - 1);
      case (idx)
         0:  s = mk_step(OP_PWR_ON,      8'h00);
         1:  s = mk_step(OP_WAIT,        8'd1);
         2:  s = mk_step(OP_RST_RELEASE, 8'h00);
         3:  s = mk_step(OP_WAIT,        8'd4);
         4:  s = mk_step(OP_RST_ASSERT,  8'h00);
         5:  s = mk_step(OP_WAIT,        8'd10);
         6:  s = mk_step(OP_RST_RELEASE, 8'h00);
         7:  s = mk_step(OP_WAIT,        8'd50);
         8:  s = mk_step(OP_CMD,         8'h01);
         9:  s = mk_step(OP_WAIT,        8'd20);
         10: s = mk_step(OP_CMD,         8'h11);
         11: s = mk_step(OP_WAIT,        8'd80);
         12: s = mk_step(OP_CMD,         8'h36);
         13: s = mk_step(OP_DATA,        8'h08);
         14: s = mk_step(OP_CMD,         8'h3A);
         15: s = mk_step(OP_DATA,        8'h66);
         16: s = mk_step(OP_CMD,         8'hC5);
         17: s = mk_step(OP_DATA,        8'h04);
         18: s = mk_step(OP_CMD,         8'h29);
         19: s = mk_step(OP_CMD,         8'h2A);
         20: s = mk_step(OP_DATA,        wl[31:24]);
         21: s = mk_step(OP_DATA,        wl[23:16]);
         22: s = mk_step(OP_DATA,        wl[15:8]);
         23: s = mk_step(OP_DATA,        wl[7:0]);
         24: s = mk_step(OP_CMD,         8'h2B);
         25: s = mk_step(OP_DATA,        hl[31:24]);
         26: s = mk_step(OP_DATA,        hl[23:16]);
         27: s = mk_step(OP_DATA,        hl[15:8]);
         28: s = mk_step(OP_DATA,        hl[7:0]);
         29: s = mk_step(OP_CMD,         8'h2C);
         30: s = mk_step(OP_END,         8'h00);
         31: s = mk_step(OP_CMD,         8'h28);
         32: s = mk_step(OP_CMD,         8'h10);
         33: s = mk_step(OP_WAIT,        8'(2 * frame_ms));
         34: s = mk_step(OP_PWR_OFF,     8'h00);
         default: s = mk_step(OP_END,    8'h00);
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
   parameter int SCALE = 2,
   parameter int ARG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [ARG_W-1:0] base_ms,
   output logic             done
);
   // One extra tick guarantees N full periods whatever the tick phase.
   localparam int MAX_LOAD = ((1 << ARG_W) - 1) * SCALE + 1;
   localparam int CW       = $clog2(MAX_LOAD + 1);

   logic [CW-1:0] load_val;
   logic [CW-1:0] cnt;

   generate
      if (SCALE == 1) begin : g_unscaled
         assign load_val = CW'(base_ms) + CW'(1);
      end else begin : g_scaled
         assign load_val = CW'(base_ms) * CW'(SCALE) + CW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= load_val;
      else if (tick && (cnt != '0))
         cnt <= cnt - CW'(1);
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/pps_step_rom.sv
module pps_step_rom
   import pps_pkg::*;
#(
   parameter int WIDTH    = 320,
   parameter int HEIGHT   = 480,
   parameter int FRAME_MS = 17
) (
   input  logic [IDX_W-1:0] idx,
   output step_t            step
);
   step_t table_q [STEP_COUNT];

   generate
      for (genvar gi = 0; gi < STEP_COUNT; gi++) begin : g_tab
         assign table_q[gi] = step_at(gi, WIDTH, HEIGHT, FRAME_MS);
      end
   endgenerate

   always_comb begin
      if (int'(idx) < STEP_COUNT)
         step = table_q[idx];
      else
         step = mk_step(OP_END, '0);
   end

endmodule

// File: rtl/pps_cmd_port.sv
module pps_cmd_port #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [BW-1:0] load_data,
   input  logic          load_dc,
   input  logic          ready,
   output logic          valid,
   output logic [BW-1:0] data_o,
   output logic          dc_o,
   output logic          accept
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         data_o <= '0;
         dc_o   <= 1'b0;
      end else if (load) begin
         valid  <= 1'b1;
         data_o <= load_data;
         dc_o   <= load_dc;
      end else if (valid && ready) begin
         valid  <= 1'b0;
      end
   end

   assign accept = valid && ready;

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
   import pps_pkg::*;
#(
   parameter int WIDTH       = 320,
   parameter int HEIGHT      = 480,
   parameter int DELAY_SCALE = 2,
   parameter int FRAME_MS    = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic              rst_pol_high,
   input  logic              en_req,
   input  logic              dis_req,
   input  logic              cmd_ready,
   output logic              pwr_en,
   output logic              panel_rst,
   output logic              cmd_valid,
   output logic              cmd_dc,
   output logic [BYTE_W-1:0] cmd_byte,
   output logic [1:0]        state
);
   localparam int ARG_W = BYTE_W;

   generate
      if (WIDTH < 1 || HEIGHT < 1) begin : g_bad_size
         $error("panel_power_seq: WIDTH and HEIGHT must be positive");
      end
      if (DELAY_SCALE < 1) begin : g_bad_scale
         $error("panel_power_seq: DELAY_SCALE must be at least 1");
      end
      if (FRAME_MS < 1 || 2 * FRAME_MS > 255) begin : g_bad_frame
         $error("panel_power_seq: 2*FRAME_MS must fit in one step argument");
      end
   endgenerate

   phase_e           phase;
   logic [IDX_W-1:0] pc;
   logic             pwr_q;
   logic             rst_asrt_q;
   logic             armed;
   logic             issued;
   logic             pend_up;
   logic             pend_down;
   step_t            cur;
   logic             running;
   logic             timer_start;
   logic             timer_done;
   logic             port_load;
   logic             port_accept;

   pps_step_rom #(
      .WIDTH   (WIDTH),
      .HEIGHT  (HEIGHT),
      .FRAME_MS(FRAME_MS)
   ) u_rom (
      .idx (pc),
      .step(cur)
   );

   pps_ms_timer #(
      .SCALE(DELAY_SCALE),
      .ARG_W(ARG_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_ms),
      .start  (timer_start),
      .base_ms(cur.arg),
      .done   (timer_done)
   );

   pps_cmd_port #(
      .BW(BYTE_W)
   ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (port_load),
      .load_data(cur.arg),
      .load_dc  (cur.op == OP_DATA),
      .ready    (cmd_ready),
      .valid    (cmd_valid),
      .data_o   (cmd_byte),
      .dc_o     (cmd_dc),
      .accept   (port_accept)
   );

   assign running     = (phase == PH_UP) || (phase == PH_DOWN);
   assign timer_start = running && (cur.op == OP_WAIT) && !armed;
   assign port_load   = running && ((cur.op == OP_CMD) || (cur.op == OP_DATA))
                        && !issued && !cmd_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_OFF;
         pc         <= '0;
         pwr_q      <= 1'b0;
         rst_asrt_q <= 1'b1;
         armed      <= 1'b0;
         issued     <= 1'b0;
         pend_up    <= 1'b0;
         pend_down  <= 1'b0;
      end else begin
         case (phase)
            PH_OFF: begin
               if (en_req || pend_up) begin
                  phase   <= PH_UP;
                  pc      <= IDX_W'(UP_ENTRY);
                  pend_up <= 1'b0;
               end
            end
            PH_ACTIVE: begin
               if (dis_req || pend_down) begin
                  phase     <= PH_DOWN;
                  pc        <= IDX_W'(DOWN_ENTRY);
                  pend_down <= 1'b0;
               end
            end
            default: begin
               if ((phase == PH_UP) && dis_req)
                  pend_down <= 1'b1;
               if ((phase == PH_DOWN) && en_req)
                  pend_up <= 1'b1;
               case (cur.op)
                  OP_PWR_ON: begin
                     pwr_q <= 1'b1;
                     pc    <= pc + IDX_W'(1);
                  end
                  OP_PWR_OFF: begin
                     pwr_q      <= 1'b0;
                     rst_asrt_q <= 1'b1;
                     pc         <= pc + IDX_W'(1);
                  end
                  OP_RST_ASSERT: begin
                     rst_asrt_q <= 1'b1;
                     pc         <= pc + IDX_W'(1);
                  end
                  OP_RST_RELEASE: begin
                     rst_asrt_q <= 1'b0;
                     pc         <= pc + IDX_W'(1);
                  end
                  OP_WAIT: begin
                     if (!armed) begin
                        armed <= 1'b1;
                     end else if (timer_done) begin
                        armed <= 1'b0;
                        pc    <= pc + IDX_W'(1);
                     end
                  end
                  OP_CMD, OP_DATA: begin
                     if (port_load) begin
                        issued <= 1'b1;
                     end else if (port_accept) begin
                        issued <= 1'b0;
                        pc     <= pc + IDX_W'(1);
                     end
                  end
                  default: begin
                     phase <= (phase == PH_UP) ? PH_ACTIVE : PH_OFF;
                  end
               endcase
            end
         endcase
      end
   end

   assign pwr_en    = pwr_q;
   assign panel_rst = rst_pol_high ? rst_asrt_q : !rst_asrt_q;
   assign state     = phase;

endmodule

// File: rtl/pps_checker.sv
module pps_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rst_pol_high,
   input logic       cmd_ready,
   input logic       pwr_en,
   input logic       panel_rst,
   input logic       cmd_valid,
   input logic       cmd_dc,
   input logic [7:0] cmd_byte,
   input logic [1:0] state
);
   a_r1_off_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0) |-> (!pwr_en && (panel_rst == rst_pol_high)));

   a_r2_from_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0) |=> (state == 2'd0 || state == 2'd1));

   a_r2_from_up: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1) |=> (state == 2'd1 || state == 2'd2));

   a_r2_from_active: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) |=> (state == 2'd2 || state == 2'd3));

   a_r2_from_down: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3) |=> (state == 2'd3 || state == 2'd0));

   a_r3_power_rises_in_up: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> (state == 2'd1));

   a_r6_power_falls_in_down: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en) |-> (state == 2'd3));

   a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_dc)));

   a_r11_active_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) |-> (pwr_en && (panel_rst != rst_pol_high) && !cmd_valid));

endmodule

bind panel_power_seq pps_checker u_pps_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rst_pol_high(rst_pol_high),
   .cmd_ready   (cmd_ready),
   .pwr_en      (pwr_en),
   .panel_rst   (panel_rst),
   .cmd_valid   (cmd_valid),
   .cmd_dc      (cmd_dc),
   .cmd_byte    (cmd_byte),
   .state       (state)
);

// File: tb/panel_power_seq_test.sv
module panel_power_seq_test;
   localparam int W     = 320;
   localparam int H     = 480;
   localparam int SCALE = 2;
   localparam int FRAME = 17;

   localparam int K_BYTE = 0;
   localparam int K_PUP  = 1;
   localparam int K_PDN  = 2;
   localparam int K_RSTA = 3;
   localparam int K_RSTR = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0;
   logic       rst_pol_high = 1'b1;
   logic       en_req = 1'b0;
   logic       dis_req = 1'b0;
   logic       cmd_ready = 1'b1;
   logic       pwr_en;
   logic       panel_rst;
   logic       cmd_valid;
   logic       cmd_dc;
   logic [7:0] cmd_byte;
   logic [1:0] state;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   bit stall_mode = 0;
   bit timing_on = 1;
   bit saw_active = 0;
   int stall_err = 0;
   int stall_seen = 0;

   int lk [64];
   int lv [64];
   int lt [64];
   int log_n = 0;
   int ek [64];
   int ev [64];
   int ems [64];
   int exp_n = 0;

   panel_power_seq #(
      .WIDTH(W), .HEIGHT(H), .DELAY_SCALE(SCALE), .FRAME_MS(FRAME)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .rst_pol_high(rst_pol_high),
      .en_req(en_req), .dis_req(dis_req), .cmd_ready(cmd_ready),
      .pwr_en(pwr_en), .panel_rst(panel_rst), .cmd_valid(cmd_valid),
      .cmd_dc(cmd_dc), .cmd_byte(cmd_byte), .state(state)
   );

   always #4 clk = ~clk;

   // millisecond tick: one cycle in eight
   initial begin
      logic [2:0] tc;
      tc = '0;
      forever begin
         @(negedge clk);
         tick_ms <= (tc == 3'd7);
         tc = tc + 3'd1;
      end
   end

   // ready pattern
   initial begin
      logic [7:0] lf;
      lf = 8'h5A;
      forever begin
         @(negedge clk);
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         cmd_ready <= stall_mode ? lf[0] : 1'b1;
      end
   end

   task automatic log_add(int k, int v, inout int ts);
      if (log_n < 64) begin
         lk[log_n] = k;
         lv[log_n] = v;
         lt[log_n] = ts;
         log_n++;
      end
      ts = 0;
   endtask

   // monitor: reads values as they stood at the preceding rising edge
   initial begin
      int   ts;
      bit   p_pwr, p_asrt, p_valid, p_dc, asrt;
      logic [7:0] p_byte;
      ts = 0; p_pwr = 0; p_asrt = 1; p_valid = 0; p_dc = 0; p_byte = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            asrt = (panel_rst == rst_pol_high);
            if (tick_ms) ts++;
            if (pwr_en != p_pwr) log_add(pwr_en ? K_PUP : K_PDN, 0, ts);
            if (asrt != p_asrt) log_add(asrt ? K_RSTA : K_RSTR, 0, ts);
            if (p_valid && cmd_ready) log_add(K_BYTE, {23'd0, p_dc, p_byte}, ts);
            if (p_valid && !cmd_ready) begin
               stall_seen++;
               if (!(cmd_valid && cmd_byte == p_byte && cmd_dc == p_dc)) stall_err++;
            end
            if (state == 2'd2) saw_active = 1;
            p_pwr = pwr_en; p_asrt = asrt; p_valid = cmd_valid;
            p_dc = cmd_dc; p_byte = cmd_byte;
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      summary();
   end

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic exp_clear();
      exp_n = 0;
   endtask

   task automatic exp_push(int k, int v, int ms);
      ek[exp_n] = k; ev[exp_n] = v; ems[exp_n] = ms;
      exp_n++;
   endtask

   task automatic exp_up();
      logic [31:0] wl, hl;
      wl = 32'(W - 1);
      hl = 32'(H - 1);
      exp_push(K_PUP, 0, -1);
      exp_push(K_RSTR, 0, 1);
      exp_push(K_RSTA, 0, 4);
      exp_push(K_RSTR, 0, 10);
      exp_push(K_BYTE, 'h001, 50);
      exp_push(K_BYTE, 'h011, 20);
      exp_push(K_BYTE, 'h036, 80);
      exp_push(K_BYTE, 'h108, -1);
      exp_push(K_BYTE, 'h03A, -1);
      exp_push(K_BYTE, 'h166, -1);
      exp_push(K_BYTE, 'h0C5, -1);
      exp_push(K_BYTE, 'h104, -1);
      exp_push(K_BYTE, 'h029, -1);
      exp_push(K_BYTE, 'h02A, -1);
      for (int i = 3; i >= 0; i--) exp_push(K_BYTE, 'h100 | int'(wl[i*8 +: 8]), -1);
      exp_push(K_BYTE, 'h02B, -1);
      for (int i = 3; i >= 0; i--) exp_push(K_BYTE, 'h100 | int'(hl[i*8 +: 8]), -1);
      exp_push(K_BYTE, 'h02C, -1);
   endtask

   task automatic exp_down();
      exp_push(K_BYTE, 'h028, -1);
      exp_push(K_BYTE, 'h010, -1);
      exp_push(K_PDN, 0, 2 * FRAME);
      exp_push(K_RSTA, 0, -1);
   endtask

   task automatic check_log(string req);
      int lo;
      chk(log_n == exp_n, req, "event count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         chk(lk[i] == ek[i] && lv[i] == ev[i], req,
             $sformatf("event %0d kind/value", i), lk[i] * 4096 + lv[i], ek[i] * 4096 + ev[i]);
         if (timing_on && ems[i] >= 0) begin
            lo = ems[i] * SCALE + 1;
            chk(lt[i] >= lo && lt[i] <= lo + 1, "R3", $sformatf("event %0d tick count", i),
                lt[i], lo);
         end
      end
   endtask

   task automatic pulse_en();
      @(negedge clk); en_req <= 1'b1;
      @(negedge clk); en_req <= 1'b0;
   endtask

   task automatic pulse_dis();
      @(negedge clk); dis_req <= 1'b1;
      @(negedge clk); dis_req <= 1'b0;
   endtask

   task automatic wait_state(int s, string req);
      int n;
      n = 0;
      while (state != 2'(s) && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(state == 2'(s), req, "reached state", state, s);
   endtask

   task automatic t_reset();
      chk(state == 2'd0, "R1", "state after reset", state, 0);
      chk(pwr_en == 1'b0, "R1", "pwr_en after reset", pwr_en, 0);
      chk(panel_rst == 1'b1, "R1", "reset pin asserted (high)", panel_rst, 1);
      chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
   endtask

   task automatic t_power_up();
      log_n = 0;
      exp_clear(); exp_up();
      pulse_en();
      chk(state == 2'd1, "R2", "state one edge after en_req", state, 1);
      wait_state(2, "R2");
      @(negedge clk);
      check_log("R4 R5");
      chk(pwr_en == 1'b1 && panel_rst == 1'b0 && cmd_valid == 1'b0, "R11",
          "active outputs pwr/rst/valid", {pwr_en, panel_rst, cmd_valid}, 3'b100);
   endtask

   task automatic t_ignore_en_active();
      int n0;
      n0 = log_n;
      pulse_en();
      repeat (40) @(negedge clk);
      chk(state == 2'd2, "R10", "en_req while active", state, 2);
      chk(log_n == n0, "R10", "no traffic after en_req while active", log_n, n0);
   endtask

   task automatic t_power_down();
      log_n = 0;
      exp_clear(); exp_down();
      pulse_dis();
      chk(state == 2'd3, "R2", "state one edge after dis_req", state, 3);
      wait_state(0, "R6");
      @(negedge clk);
      check_log("R6");
      chk(pwr_en == 1'b0 && panel_rst == 1'b1, "R6", "off outputs pwr/rst",
          {pwr_en, panel_rst}, 2'b01);
   endtask

   task automatic t_ignore_dis_off();
      log_n = 0;
      pulse_dis();
      repeat (40) @(negedge clk);
      chk(state == 2'd0, "R10", "dis_req while off", state, 0);
      chk(log_n == 0, "R10", "no events after dis_req while off", log_n, 0);
   endtask

   task automatic t_polarity();
      @(negedge clk); rst_pol_high <= 1'b0;
      @(negedge clk);
      chk(panel_rst == 1'b0, "R8", "active-low pin asserted while off", panel_rst, 0);
   endtask

   task automatic t_stall_and_held_disable();
      stall_mode = 1; timing_on = 0; saw_active = 0;
      log_n = 0;
      exp_clear(); exp_up(); exp_down();
      pulse_en();
      repeat (30) @(negedge clk);
      chk(state == 2'd1, "R9", "still powering up when disable arrives", state, 1);
      pulse_dis();
      wait_state(0, "R9");
      @(negedge clk);
      chk(saw_active, "R9", "active reached before held disable acted", saw_active, 1);
      check_log("R7 R9");
      chk(stall_seen > 0, "R7", "stalls occurred", stall_seen, 1);
      chk(stall_err == 0, "R7", "byte held under stall", stall_err, 0);
      chk(panel_rst == 1'b0, "R8", "active-low pin asserted after power-down", panel_rst, 0);
      stall_mode = 0; timing_on = 1;
   endtask

   task automatic t_held_enable();
      pulse_en();
      wait_state(2, "R9");
      @(negedge clk);
      chk(panel_rst == 1'b1, "R8", "active-low pin released when active", panel_rst, 1);
      log_n = 0;
      exp_clear(); exp_down(); exp_up();
      pulse_dis();
      repeat (20) @(negedge clk);
      chk(state == 2'd3, "R9", "powering down when enable arrives", state, 3);
      pulse_en();
      wait_state(0, "R9");
      wait_state(2, "R9");
      @(negedge clk);
      check_log("R9");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n <= 1'b1;
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_power_up();
      t_ignore_en_active();
      t_power_down();
      t_ignore_dis_off();
      t_polarity();
      t_stall_and_held_disable();
      t_held_enable();
      summary();
   end

endmodule